// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital side of a two-channel 16-bit converter. A host shifts 24-bit command words into a serial shift register. The shift register clocks on the rising edge of the OR of the active-low chip select and the serial clock. The top bit of the shift register is driven straight out on a serial data pin, so the next device in a chain can take the same stream.

Each channel has two registers in series. A level-sensitive write strobe copies the code field of the shift register into one channel's staging register, chosen by a select bit, or into both staging registers when a broadcast bit is set. A rising edge on the update strobe then moves both staging registers into the two output code registers in the same cycle. A rising edge on the clear input forces all four code registers to mid-scale or zero-scale and leaves the shift register alone.

All pins are sampled in one system clock domain through two-flop synchronizers, and edges are found from the synchronized values. A small write-control machine has two states. `LD_IDLE` means the write strobe is released. `LD_TRACK` means the write strobe is held and the addressed staging registers follow the shift register. The transition `wr_assert` moves LD_IDLE to LD_TRACK when the synchronized strobe is low. The transition `wr_release` moves LD_TRACK back to LD_IDLE when the strobe is high. Both states hold while the strobe keeps its level. The system clock must run at least four times faster than the serial clock.

Top module: `dual_dac_serial_if`

## Requirements
- R1: Command word fields: bit 23 picks the channel (0 = A, 1 = B), bit 21 is the broadcast flag, and bits 15..0 are the straight-binary code. Bits 22 and 20..16 have no effect.
- R2: The shift register takes one bit, MSB first, on each rising edge of (sel_n_i OR sclk_i). Either input can act as the shift clock. While either input is held high, the shift register holds.
- R3: If sel_n_i rises while sclk_i is low, the shift register takes one extra bit (the current sdata_i).
- R4: While wr_n_i is low, the shift register code goes into the staging register of the selected channel. It goes into both staging registers when the broadcast bit is 1.
- R5: If shifting continues while wr_n_i stays low, the selected staging registers follow the changing shift register contents.
- R6: A rising edge of upd_i copies both staging registers to code_a_o and code_b_o in the same cycle. Holding upd_i high has no further effect, and the outputs do not change without such an edge.
- R7: A rising edge of clr_i sets all four code registers to 16'h8000 if clr_mid_i is 1, or to 16'h0000 if clr_mid_i is 0. The shift register is not changed.
- R8: sdata_o always equals bit 23 of the shift register.
- R9: While rst_ni is low at a clock edge, the shift register clears to zero and all code registers clear to 16'h0000.
- R10: A clear edge in the same system cycle as an update edge, or while the write strobe is active, wins for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low system reset |
| sel_n_i | input | 1 | Active-low chip select, ORed with the serial clock |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial command data in |
| wr_n_i | input | 1 | Active-low level write strobe into staging registers |
| upd_i | input | 1 | Update strobe, rising-edge active |
| clr_i | input | 1 | Clear strobe, rising-edge active |
| clr_mid_i | input | 1 | Clear value select: 1 = mid-scale, 0 = zero-scale |
| code_a_o | output | 16 | Channel A output code |
| code_b_o | output | 16 | Channel B output code |
| sdata_o | output | 1 | Serial data out (shift register bit 23) |

## Verification
A shift register that is off by one bit shows at sdata_o within one serial period. It also sends later writes to the wrong channel or sets the broadcast bit by mistake. Faults in the staging registers cannot be seen until the next update edge, so the bench follows every write with an update, and it compares both codes and sdata_o against a reference model on every system cycle. A write machine stuck in LD_IDLE or LD_TRACK either loses writes or lets staging follow later shifting. A clear that disturbs the shifter shows up as a wrong code on the first write after the clear.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
    localparam int CMD_BITS  = 24;
    localparam int CODE_BITS = 16;
    localparam int N_CH      = 2;

    // pin positions inside the synchronizer vector
    localparam int PIN_SEL   = 0;
    localparam int PIN_SCLK  = 1;
    localparam int PIN_DATA  = 2;
    localparam int PIN_WR    = 3;
    localparam int PIN_UPD   = 4;
    localparam int PIN_CLR   = 5;
    localparam int PIN_MID   = 6;
    localparam int N_PINS    = 7;

    // idle level of each pin, loaded into the synchronizers at reset
    localparam logic [N_PINS-1:0] PIN_IDLE = 7'b000_1011;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_TRACK = 1'b1
    } ld_state_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic meta_q, lvl_q, prev_q;
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    meta_q <= RST_VAL[b];
                    lvl_q  <= RST_VAL[b];
                    prev_q <= RST_VAL[b];
                end else begin
                    meta_q <= pins_i[b];
                    lvl_q  <= meta_q;
                    prev_q <= lvl_q;
                end
            end
            assign lvl_o[b]  = lvl_q;
            assign prev_o[b] = prev_q;
        end
    endgenerate
endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter #(
    parameter int W = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)     word_q <= '0;
        else if (step_i) word_q <= {word_q[W-2:0], bit_i};
    end

    assign word_o = word_q;

    assert_shift_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |=> (word_o[W-1:1] == $past(word_o[W-2:0])) && (word_o[0] == $past(bit_i)));

    assert_shift_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(word_o));
endmodule

// File: rtl/chan_regs.sv
module chan_regs
    import dac_if_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int NCH    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_n_i,
    input  logic              ch_sel_i,
    input  logic              bcast_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              upd_edge_i,
    input  logic              clr_edge_i,
    input  logic              clr_mid_i,
    output logic [CODE_W-1:0] out_o [NCH]
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    ld_state_e         state_q, state_d;
    logic [NCH-1:0]    wr_en;
    logic [CODE_W-1:0] clr_code;
    logic [CODE_W-1:0] stage_q [NCH];
    logic [CODE_W-1:0] out_q   [NCH];

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= LD_IDLE;
        else         state_q <= state_d;
    end

    // transitions: wr_assert / wr_release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:  if (!wr_n_i) state_d = LD_TRACK;
            LD_TRACK: if (wr_n_i)  state_d = LD_IDLE;
            default:  state_d = LD_IDLE;
        endcase
    end

    assign clr_code = clr_mid_i ? MID_CODE : '0;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign wr_en[c] = (state_q == LD_TRACK) && (bcast_i || (ch_sel_i == c[0]));

            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    stage_q[c] <= '0;
                    out_q[c]   <= '0;
                end else if (clr_edge_i) begin
                    stage_q[c] <= clr_code;
                    out_q[c]   <= clr_code;
                end else begin
                    if (wr_en[c])   stage_q[c] <= code_i;
                    if (upd_edge_i) out_q[c]   <= stage_q[c];
                end
            end

            assign out_o[c] = out_q[c];

            assert_upd_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (upd_edge_i && !clr_edge_i) |=> out_q[c] == $past(stage_q[c]));

            assert_out_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!upd_edge_i && !clr_edge_i) |=> $stable(out_q[c]));

            assert_clr_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                clr_edge_i |=> (out_q[c] == (clr_mid_i ? MID_CODE : '0)) && (stage_q[c] == out_q[c]));
        end
    endgenerate

    assert_track_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == LD_TRACK && !clr_edge_i && !bcast_i && !ch_sel_i) |=> stage_q[0] == $past(code_i));

    assert_bcast_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == LD_TRACK && !clr_edge_i && bcast_i) |=> stage_q[0] == stage_q[NCH-1]);

    assert_clr_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_edge_i |=> (out_q[0] == $past(clr_code)));
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
    import dac_if_pkg::*;
#(
    parameter int CMD_W  = CMD_BITS,
    parameter int CODE_W = CODE_BITS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              wr_n_i,
    input  logic              upd_i,
    input  logic              clr_i,
    input  logic              clr_mid_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              sdata_o
);
    localparam int SEL_POS   = CMD_W - 1;
    localparam int BCAST_POS = CMD_W - 3;

    logic [N_PINS-1:0] pins, lvl, prev;
    logic              shift_clk_now, shift_clk_was;
    logic              step, upd_edge, clr_edge;
    logic [CMD_W-1:0]  word;
    logic [CODE_W-1:0] outs [N_CH];

    assign pins[PIN_SEL]  = sel_n_i;
    assign pins[PIN_SCLK] = sclk_i;
    assign pins[PIN_DATA] = sdata_i;
    assign pins[PIN_WR]   = wr_n_i;
    assign pins[PIN_UPD]  = upd_i;
    assign pins[PIN_CLR]  = clr_i;
    assign pins[PIN_MID]  = clr_mid_i;

    pin_sync #(.W(N_PINS), .RST_VAL(PIN_IDLE)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (pins),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    assign shift_clk_now = lvl[PIN_SEL]  | lvl[PIN_SCLK];
    assign shift_clk_was = prev[PIN_SEL] | prev[PIN_SCLK];
    assign step          = shift_clk_now & ~shift_clk_was;
    assign upd_edge      = lvl[PIN_UPD] & ~prev[PIN_UPD];
    assign clr_edge      = lvl[PIN_CLR] & ~prev[PIN_CLR];

    cmd_shifter #(.W(CMD_W)) u_shift (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (step),
        .bit_i  (lvl[PIN_DATA]),
        .word_o (word)
    );

    chan_regs #(.CODE_W(CODE_W), .NCH(N_CH)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_n_i     (lvl[PIN_WR]),
        .ch_sel_i   (word[SEL_POS]),
        .bcast_i    (word[BCAST_POS]),
        .code_i     (word[CODE_W-1:0]),
        .upd_edge_i (upd_edge),
        .clr_edge_i (clr_edge),
        .clr_mid_i  (lvl[PIN_MID]),
        .out_o      (outs)
    );

    assign code_a_o = outs[0];
    assign code_b_o = outs[N_CH-1];
    assign sdata_o  = word[SEL_POS];

    assert_clr_keeps_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_edge && !step) |=> $stable(word));
endmodule

// File: tb/dual_dac_serial_if_tb.sv
module dual_dac_serial_if_tb;
    localparam int HP = 6;
    localparam logic [6:0] IDLE = 7'b000_1011;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, sel_n = 1'b1, sclk = 1'b1, sdata = 1'b0;
    logic wr_n = 1'b1, upd = 1'b0, clr = 1'b0, clr_mid = 1'b0;
    logic [15:0] code_a, code_b;
    logic        sdo;

    int checks = 0, errors = 0;
    bit done = 0, seen_rst = 0;

    dual_dac_serial_if u_dut (
        .clk_i(clk), .rst_ni(rst_n), .sel_n_i(sel_n), .sclk_i(sclk),
        .sdata_i(sdata), .wr_n_i(wr_n), .upd_i(upd), .clr_i(clr),
        .clr_mid_i(clr_mid), .code_a_o(code_a), .code_b_o(code_b), .sdata_o(sdo)
    );

    // behavioural reference model, updated once per system clock
    logic [6:0]  h0, h1, h2, h3;
    logic [23:0] m_sh;
    logic [15:0] m_in [0:1];
    logic [15:0] m_out [0:1];
    logic        m_trk;

    always @(posedge clk) begin
        logic [15:0] n_in [0:1];
        logic [15:0] n_out [0:1];
        logic e_sh, e_upd, e_clr;
        if (!rst_n) begin
            seen_rst = 1;
            h0 = IDLE; h1 = IDLE; h2 = IDLE; h3 = IDLE;
            m_sh = '0; m_trk = 0;
            for (int c = 0; c < 2; c++) begin m_in[c] = '0; m_out[c] = '0; end
        end else begin
            h3 = h2; h2 = h1; h1 = h0;
            h0 = {clr_mid, clr, upd, wr_n, sdata, sclk, sel_n};
            e_sh  = (h2[0] | h2[1]) && !(h3[0] | h3[1]);
            e_upd = h2[4] && !h3[4];
            e_clr = h2[5] && !h3[5];
            for (int c = 0; c < 2; c++) begin n_in[c] = m_in[c]; n_out[c] = m_out[c]; end
            if (e_clr) begin
                for (int c = 0; c < 2; c++) begin
                    n_in[c]  = h2[6] ? 16'h8000 : 16'h0000;
                    n_out[c] = n_in[c];
                end
            end else begin
                for (int c = 0; c < 2; c++) begin
                    if (m_trk && (m_sh[21] || (m_sh[23] == c[0]))) n_in[c] = m_sh[15:0];
                    if (e_upd) n_out[c] = m_in[c];
                end
            end
            if (e_sh) m_sh = {m_sh[22:0], h2[2]};
            m_trk = !h2[3];
            for (int c = 0; c < 2; c++) begin m_in[c] = n_in[c]; m_out[c] = n_out[c]; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (seen_rst && rst_n && !done) begin
            checks++;
            if (code_a !== m_out[0] || code_b !== m_out[1] || sdo !== m_sh[23]) begin
                errors++;
                $display("FAIL model R4/R6/R8 a=%h/%h b=%h/%h sdo=%b/%b (actual/expected)",
                         code_a, m_out[0], code_b, m_out[1], sdo, m_sh[23]);
            end
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic sys(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [23:0] w, bit cs_as_clk, bit tail_low);
        if (!cs_as_clk) begin
            sel_n = 0; sys(HP);
            for (int i = 23; i >= 0; i--) begin
                sclk = 0; sdata = w[i]; sys(HP);
                sclk = 1; sys(HP);
            end
            if (tail_low) begin
                sclk = 0; sdata = 1; sys(HP);
                sel_n = 1; sys(HP);
                sclk = 1; sys(HP);
            end else begin
                sel_n = 1; sys(HP);
            end
        end else begin
            sclk = 0; sys(HP);
            for (int i = 23; i >= 0; i--) begin
                sel_n = 0; sdata = w[i]; sys(HP);
                sel_n = 1; sys(HP);
            end
            sclk = 1; sys(HP);
        end
    endtask

    task automatic pulse_wr();
        wr_n = 0; sys(8); wr_n = 1; sys(6);
    endtask

    task automatic pulse_upd();
        upd = 1; sys(4); upd = 0; sys(8);
    endtask

    task automatic pulse_clr(bit mid);
        clr_mid = mid; sys(4); clr = 1; sys(4); clr = 0; sys(8);
    endtask

    initial begin
        sys(6);
        rst_n = 1; sys(2);
        chk("R9 reset code_a", code_a, 16'h0000);
        chk("R9 reset code_b", code_b, 16'h0000);
        chk("R9 reset sdo", {15'b0, sdo}, 16'h0000);

        // R1: ignored bits 22 and 20..16 set, broadcast clear, channel A
        send(24'h5F_A5C3, 0, 0); pulse_wr(); pulse_upd();
        chk("R1 ignored bits code_a", code_a, 16'hA5C3);
        chk("R1 channel B untouched", code_b, 16'h0000);

        // R6 double buffering: write B, outputs hold until update
        send(24'h80_1F2E, 0, 0); pulse_wr();
        chk("R6 before update code_b", code_b, 16'h0000);
        pulse_upd();
        chk("R4 write B code_b", code_b, 16'h1F2E);
        chk("R4 write B keeps A", code_a, 16'hA5C3);

        // R4 broadcast
        send(24'h20_7777, 0, 0); pulse_wr(); pulse_upd();
        chk("R4 broadcast code_a", code_a, 16'h7777);
        chk("R4 broadcast code_b", code_b, 16'h7777);

        // R2 chip select used as shift clock
        send(24'h80_0042, 1, 0); pulse_wr(); pulse_upd();
        chk("R2 cs-clocked code_b", code_b, 16'h0042);
        chk("R8 sdo is bit 23", {15'b0, sdo}, 16'h0001);

        // R2 hold: clock toggles with select high
        sdata = 0;
        for (int i = 0; i < 3; i++) begin sclk = 0; sys(HP); sclk = 1; sys(HP); end
        chk("R2 hold sdo", {15'b0, sdo}, 16'h0001);
        pulse_wr(); pulse_upd();
        chk("R2 hold code_b", code_b, 16'h0042);

        // R6 level on update has no further effect
        upd = 1; sys(8);
        send(24'h00_0BEE, 0, 0); pulse_wr();
        chk("R6 level held code_a", code_a, 16'h7777);
        upd = 0; sys(6); upd = 1; sys(8); upd = 0; sys(4);
        chk("R6 new edge code_a", code_a, 16'h0BEE);

        // R5 tracking while write strobe stays low
        wr_n = 0; sys(8);
        send(24'h00_3C3C, 0, 0);
        sys(8); wr_n = 1; sys(6); pulse_upd();
        chk("R5 tracked code_a", code_a, 16'h3C3C);

        // R3 select rises while clock low: one extra bit (1)
        send(24'h80_0A5A, 0, 1);
        chk("R3 extra shift sdo", {15'b0, sdo}, 16'h0000);
        pulse_wr(); pulse_upd();
        chk("R3 extra shift code_a", code_a, 16'h14B5);

        // R7 clear to mid-scale, shift register preserved
        pulse_clr(1);
        chk("R7 mid code_a", code_a, 16'h8000);
        chk("R7 mid code_b", code_b, 16'h8000);
        pulse_wr(); pulse_upd();
        chk("R7 shifter kept code_a", code_a, 16'h14B5);
        chk("R7 shifter kept code_b", code_b, 16'h8000);

        pulse_clr(0);
        chk("R7 zero code_a", code_a, 16'h0000);
        chk("R7 zero code_b", code_b, 16'h0000);

        // R10 clear and update edges together while writing
        clr_mid = 1; wr_n = 0; sys(8);
        clr = 1; upd = 1; sys(4); clr = 0; upd = 0; sys(8);
        chk("R10 clear wins code_a", code_a, 16'h8000);
        chk("R10 clear wins code_b", code_b, 16'h8000);
        wr_n = 1; sys(6); pulse_upd();
        chk("R10 write resumes code_a", code_a, 16'h14B5);
        chk("R10 write resumes code_b", code_b, 16'h8000);

        sys(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog R2 actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule